// File: doc/BRIEF.md
# Chip-Select Buffer Enable Sequencer

This block sits between an internal bus controller and the external pins. It turns per-select internal access requests into active-low chip-select pins. It also drives two active-low enables for external address and data buffers. Each select has its own lead time and trail time, both counted in clocks. The buffer enable goes active as soon as a request is seen. The chip-select pin falls only after the lead time has passed. After the pin rises, the enable stays active for the trail time. The lead therefore comes from holding back the chip-select falling edge. Because the cycle still ends when the request ends, a cycle that ends early is shorter on the pin by the lead time.

Pin 0 is shared by two logical selects, select 0 and select 4. In boot-remap mode, select 0 is used only inside the chip. Pin 0 then follows select 4's request and timing values. Buffer enable 1 always covers pin 0. Buffer enable 2 is always off while pin 0 is active. Each enable can also be routed to the windows of pins 1 and 2.

Top module: `cbe_seq`

## Requirements
- R1: During and after a synchronous reset, every chip-select pin and both buffer enables are high (inactive).
- R2: A request seen at clock edge t drives its chip-select pin low at edge t+L, where L is that select's 4-bit lead value. When L=0, the pin falls at edge t.
- R3: The buffer-enable window of a pin opens at the edge where its request is first seen, which is L clocks before the chip-select pin falls.
- R4: The chip-select pin returns high at the first edge where its request is sampled low or the termination input is sampled high. If this happens during the lead time, the pin never goes low.
- R5: After the pin returns high, the window stays open for T more clocks, where T is that select's 4-bit trail value. When T=0, the window closes at the same edge as the pin rises.
- R6: If termination ends a cycle while the request is still high, no new cycle starts until the request has been sampled low.
- R7: Buffer enable 1 is low whenever the window of pin 0 is open. Buffer enable 2 is high whenever pin 0 is low.
- R8: Route bits add pins 1 and 2 to an enable. In be1_route_i and be2_route_i, bit 0 adds the window of pin 1 and bit 1 adds the window of pin 2.
- R9: Request bit i and config slot i (bits 4i+3:4i) belong to select i. When boot_remap_i is 1, pin 0 uses request bit 4 and slot 4, and request bit 0 has no effect on any output. When boot_remap_i is 0, pin 0 uses bit 0 and slot 0.
- R10: A new request that arrives while a pin's window is in its trail time starts a new cycle. The window and the enables stay low with no high pulse between the two cycles.
- R11: Each select uses only its own lead and trail values, so pins can run at the same time with different timings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 5 | Internal access requests per select, active high (bit 4 = alternate select for pin 0) |
| term_i | input | 1 | Internal cycle-termination indication |
| boot_remap_i | input | 1 | 1: pin 0 follows select 4 |
| lead_cfg_i | input | 20 | 4-bit lead count per select |
| trail_cfg_i | input | 20 | 4-bit trail count per select |
| be1_route_i | input | 2 | Extra pins for enable 1 (bit0 pin 1, bit1 pin 2) |
| be2_route_i | input | 2 | Extra pins for enable 2 (bit0 pin 1, bit1 pin 2) |
| cs_n_o | output | 4 | Chip-select pins, active low |
| be1_n_o | output | 1 | Buffer enable 1, active low |
| be2_n_o | output | 1 | Buffer enable 2, active low |

## Verification
The assertions check the following relationships on every cycle:
- an active pin always has its window open;
- a nonzero lead opens the window before the pin falls;
- a nonzero trail keeps the window open past the pin's rising edge;
- a stop condition always releases the pin;
- enable 2 never overlaps pin 0, and enable 1 always covers pin 0.

Only the bench's scenarios can show the exact clock counts for lead and trail, and that a cycle ended early is shorter by the lead time. The same holds for the re-arm rule after termination, for a retrigger during the trail with no glitch, for the boot remap (including that request 0 is ignored), and for the route bit positions.

// File: rtl/cbe_pkg.sv
package cbe_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LEAD = 2'd1,
    ST_ACT  = 2'd2,
    ST_TAIL = 2'd3
  } slot_st_e;
endpackage

// File: rtl/cbe_slot.sv
module cbe_slot #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_i,
  input  logic             term_i,
  input  logic [CNT_W-1:0] lead_i,
  input  logic [CNT_W-1:0] trail_i,
  output logic             cs_n_o,
  output logic             win_o,
  output logic             cs_nxt_o,
  output logic             win_nxt_o
);
  import cbe_pkg::*;

  slot_st_e         st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             blk_q, blk_d;
  logic             cs_n_q, win_q;
  logic             cs_d, win_d;
  logic             start, stop;

  assign start = req_i && !blk_q;
  assign stop  = !req_i || term_i;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    blk_d = blk_q;
    cs_d  = !cs_n_q;
    win_d = win_q;
    case (st_q)
      ST_IDLE, ST_TAIL: begin
        if (start) begin
          win_d = 1'b1;
          if (lead_i == '0) begin
            cs_d = 1'b1;
            st_d = ST_ACT;
          end else begin
            cnt_d = lead_i;
            st_d  = ST_LEAD;
          end
        end else if (st_q == ST_TAIL) begin
          if (cnt_q == CNT_W'(1)) begin
            win_d = 1'b0;
            st_d  = ST_IDLE;
          end else begin
            cnt_d = cnt_q - CNT_W'(1);
          end
        end
      end
      ST_LEAD, ST_ACT: begin
        if (stop) begin
          cs_d = 1'b0;
          if (req_i && term_i) blk_d = 1'b1;
          if (trail_i == '0) begin
            win_d = 1'b0;
            st_d  = ST_IDLE;
          end else begin
            cnt_d = trail_i;
            st_d  = ST_TAIL;
          end
        end else if (st_q == ST_LEAD) begin
          if (cnt_q == CNT_W'(1)) begin
            cs_d = 1'b1;
            st_d = ST_ACT;
          end else begin
            cnt_d = cnt_q - CNT_W'(1);
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
    if (!req_i) blk_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      blk_q  <= 1'b0;
      cs_n_q <= 1'b1;
      win_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      blk_q  <= blk_d;
      cs_n_q <= !cs_d;
      win_q  <= win_d;
    end
  end

  assign cs_n_o    = cs_n_q;
  assign win_o     = win_q;
  assign cs_nxt_o  = cs_d;
  assign win_nxt_o = win_d;

  // R3: an active pin always lies inside its window
  p_cs_in_win_r3: assert property (@(posedge clk) disable iff (rst)
    !cs_n_q |-> win_q);

  // R3: nonzero lead means the window was already open when the pin falls
  p_lead_r3: assert property (@(posedge clk) disable iff (rst)
    ($fell(cs_n_q) && ($past(lead_i) != '0)) |-> $past(win_q));

  // R5: nonzero trail keeps the window open at the rising edge of the pin
  p_trail_r5: assert property (@(posedge clk) disable iff (rst)
    ($rose(cs_n_q) && ($past(trail_i) != '0)) |-> win_q);

  // R4: a stop condition always releases the pin on the next edge
  p_stop_r4: assert property (@(posedge clk) disable iff (rst)
    (!cs_n_q && stop) |=> cs_n_q);

  // R5: the trail counter never sits at zero while counting
  p_tail_cnt_r5: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_TAIL) |-> (cnt_q != '0));
endmodule

// File: rtl/cbe_bufen.sv
module cbe_bufen #(
  parameter int NUM_PIN = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_PIN-1:0] win_nxt_i,
  input  logic               cs0_nxt_i,
  input  logic [1:0]         be1_route_i,
  input  logic [1:0]         be2_route_i,
  output logic               be1_n_o,
  output logic               be2_n_o
);
  logic [1:0] extra1, extra2;
  logic       be1_d, be2_d;

  for (genvar k = 0; k < 2; k++) begin : g_route
    assign extra1[k] = be1_route_i[k] && win_nxt_i[k+1];
    assign extra2[k] = be2_route_i[k] && win_nxt_i[k+1];
  end

  assign be1_d = win_nxt_i[0] || (|extra1);
  assign be2_d = (|extra2) && !cs0_nxt_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      be1_n_o <= 1'b1;
      be2_n_o <= 1'b1;
    end else begin
      be1_n_o <= !be1_d;
      be2_n_o <= !be2_d;
    end
  end
endmodule

// File: rtl/cbe_seq.sv
module cbe_seq #(
  parameter int NUM_PIN = 4,
  parameter int CNT_W   = 4,
  localparam int NUM_SEL = NUM_PIN + 1,
  localparam int ALT_SEL = NUM_PIN
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_SEL-1:0]       req_i,
  input  logic                     term_i,
  input  logic                     boot_remap_i,
  input  logic [NUM_SEL*CNT_W-1:0] lead_cfg_i,
  input  logic [NUM_SEL*CNT_W-1:0] trail_cfg_i,
  input  logic [1:0]               be1_route_i,
  input  logic [1:0]               be2_route_i,
  output logic [NUM_PIN-1:0]       cs_n_o,
  output logic                     be1_n_o,
  output logic                     be2_n_o
);
  logic [NUM_PIN-1:0] win_q, win_nxt, cs_nxt;

  for (genvar p = 0; p < NUM_PIN; p++) begin : g_pin
    logic             p_req;
    logic [CNT_W-1:0] p_lead, p_trail;
    if (p == 0) begin : g_shared
      assign p_req   = boot_remap_i ? req_i[ALT_SEL] : req_i[0];
      assign p_lead  = boot_remap_i ? lead_cfg_i[ALT_SEL*CNT_W +: CNT_W]
                                    : lead_cfg_i[0 +: CNT_W];
      assign p_trail = boot_remap_i ? trail_cfg_i[ALT_SEL*CNT_W +: CNT_W]
                                    : trail_cfg_i[0 +: CNT_W];
    end else begin : g_plain
      assign p_req   = req_i[p];
      assign p_lead  = lead_cfg_i[p*CNT_W +: CNT_W];
      assign p_trail = trail_cfg_i[p*CNT_W +: CNT_W];
    end
    cbe_slot #(.CNT_W(CNT_W)) u_slot (
      .clk       (clk),
      .rst       (rst),
      .req_i     (p_req),
      .term_i    (term_i),
      .lead_i    (p_lead),
      .trail_i   (p_trail),
      .cs_n_o    (cs_n_o[p]),
      .win_o     (win_q[p]),
      .cs_nxt_o  (cs_nxt[p]),
      .win_nxt_o (win_nxt[p])
    );
  end

  cbe_bufen #(.NUM_PIN(NUM_PIN)) u_bufen (
    .clk         (clk),
    .rst         (rst),
    .win_nxt_i   (win_nxt),
    .cs0_nxt_i   (cs_nxt[0]),
    .be1_route_i (be1_route_i),
    .be2_route_i (be2_route_i),
    .be1_n_o     (be1_n_o),
    .be2_n_o     (be2_n_o)
  );

  // R7: enable 2 never overlaps an active pin 0
  p_be2_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !cs_n_o[0] |-> be2_n_o);

  // R7: enable 1 covers the whole window of pin 0
  p_be1_cover_r7: assert property (@(posedge clk) disable iff (rst)
    win_q[0] |-> !be1_n_o);
endmodule

// File: tb/cbe_seq_test.sv
`timescale 1ns/100ps
module cbe_seq_test;
  logic        clk = 1'b0;
  logic        rst;
  logic [4:0]  req;
  logic        term;
  logic        boot;
  logic [19:0] lead_cfg, trail_cfg;
  logic [1:0]  r1, r2;
  logic [3:0]  cs_n;
  logic        be1_n, be2_n;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  cbe_seq uut (
    .clk(clk), .rst(rst), .req_i(req), .term_i(term), .boot_remap_i(boot),
    .lead_cfg_i(lead_cfg), .trail_cfg_i(trail_cfg),
    .be1_route_i(r1), .be2_route_i(r2),
    .cs_n_o(cs_n), .be1_n_o(be1_n), .be2_n_o(be2_n)
  );

  // behavioural reference
  bit m_cs[4], m_win[4], m_blk[4];
  int m_wait[4], m_hold[4];
  logic [3:0] exp_cs_n;
  logic exp_be1, exp_be2;

  task automatic check(string t, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", t, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      for (int p = 0; p < 4; p++) begin
        m_cs[p] = 0; m_win[p] = 0; m_blk[p] = 0; m_wait[p] = 0; m_hold[p] = 0;
      end
    end else begin
      for (int p = 0; p < 4; p++) begin
        int sel, pr, po;
        bit r, stp, bo;
        sel = (p == 0 && boot) ? 4 : p;
        r   = req[sel];
        pr  = lead_cfg[sel*4 +: 4];
        po  = trail_cfg[sel*4 +: 4];
        stp = !r || term;
        bo  = m_blk[p];
        if (m_cs[p] || m_wait[p] > 0) begin
          if (stp) begin
            m_cs[p] = 0; m_wait[p] = 0;
            if (r && term) m_blk[p] = 1;
            if (po == 0) m_win[p] = 0; else m_hold[p] = po;
          end else if (!m_cs[p]) begin
            m_wait[p]--;
            if (m_wait[p] == 0) m_cs[p] = 1;
          end
        end else if (r && !bo) begin
          m_win[p] = 1; m_hold[p] = 0;
          if (pr == 0) m_cs[p] = 1; else m_wait[p] = pr;
        end else if (m_hold[p] > 0) begin
          m_hold[p]--;
          if (m_hold[p] == 0) m_win[p] = 0;
        end
        if (!r) m_blk[p] = 0;
      end
    end
    for (int p = 0; p < 4; p++) exp_cs_n[p] = !m_cs[p];
    exp_be1 = !(m_win[0] || (r1[0] && m_win[1]) || (r1[1] && m_win[2]));
    exp_be2 = !(((r2[0] && m_win[1]) || (r2[1] && m_win[2])) && !m_cs[0]);
    #1;
    check({tag, " cs_n"}, 32'(cs_n), 32'(exp_cs_n));
    check({tag, " be1_n"}, 32'(be1_n), 32'(exp_be1));
    check({tag, " be2_n"}, 32'(be2_n), 32'(exp_be2));
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(int sel, int len);
    @(negedge clk); req[sel] = 1'b1;
    repeat (len) @(negedge clk);
    req[sel] = 1'b0;
  endtask

  task automatic cfg(int sel, int ld, int tr);
    lead_cfg[sel*4 +: 4]  = 4'(ld);
    trail_cfg[sel*4 +: 4] = 4'(tr);
  endtask

  initial begin
    rst = 1; req = '0; term = 0; boot = 0; lead_cfg = '0; trail_cfg = '0;
    r1 = 2'b00; r2 = 2'b00;
    idle(4);
    tag = "R1";
    check("R1 reset cs_n", 32'(cs_n), 32'hF);
    check("R1 reset be1_n", 32'(be1_n), 32'h1);
    check("R1 reset be2_n", 32'(be2_n), 32'h1);
    rst = 0;
    idle(2);

    tag = "R2"; r1 = 2'b01; cfg(1, 3, 0);
    pulse(1, 8); idle(4);
    tag = "R3"; cfg(3, 0, 0);
    pulse(3, 4); idle(4);
    tag = "R3"; cfg(1, 1, 0);
    pulse(1, 3); idle(4);

    tag = "R5"; r2 = 2'b10; cfg(2, 2, 3);
    pulse(2, 6); idle(6);

    tag = "R4"; cfg(1, 3, 1);
    pulse(1, 2); idle(4);
    pulse(1, 3); idle(4);

    tag = "R6"; cfg(1, 1, 2);
    @(negedge clk); req[1] = 1;
    idle(4); term = 1; idle(1); term = 0;
    idle(4); req[1] = 0; idle(2);
    pulse(1, 3); idle(5);

    tag = "R7"; r1 = 2'b00; r2 = 2'b01; cfg(0, 2, 2); cfg(1, 0, 4);
    @(negedge clk); req[1] = 1; idle(2); req[0] = 1;
    idle(5); req[0] = 0; idle(3); req[1] = 0; idle(8);

    tag = "R9"; boot = 1; cfg(4, 2, 1); cfg(0, 0, 0);
    pulse(0, 5); idle(3);
    pulse(4, 6); idle(4);
    @(negedge clk); req[0] = 1; req[4] = 1; idle(4); req[4] = 0; idle(3); req[0] = 0;
    idle(4); boot = 0; idle(2);

    tag = "R10"; cfg(0, 2, 5);
    pulse(0, 3); idle(2); pulse(0, 3); idle(8);
    cfg(2, 0, 3); r1 = 2'b10;
    pulse(2, 2); idle(1); pulse(2, 2); idle(6);

    tag = "R11"; cfg(1, 1, 2); cfg(2, 3, 1); cfg(3, 0, 4);
    @(negedge clk); req[1] = 1; req[2] = 1; req[3] = 1;
    idle(6); req[1] = 0; idle(1); req[3] = 0; idle(1); req[2] = 0; idle(8);

    tag = "R8"; r1 = 2'b10; r2 = 2'b01; cfg(1, 1, 1); cfg(2, 2, 2);
    pulse(1, 4); idle(4); pulse(2, 4); idle(5);
    r1 = 2'b01; r2 = 2'b10;
    pulse(1, 4); idle(4); pulse(2, 4); idle(5);
    r1 = 2'b11; r2 = 2'b11;
    @(negedge clk); req[1] = 1; idle(2); req[2] = 1; idle(3); req[1] = 0; idle(2); req[2] = 0;
    idle(6);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule